// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed instruction of the 64-bit RISC-V integer set into the equivalent standard 32-bit encoding. A fetch or decode stage places the next instruction word on `instr` and qualifies it with `in_valid`. When the two lowest bits of `instr` are `11`, the word is already a full-length instruction and leaves the block unchanged. Otherwise only the low halfword is expanded and bits 31:16 are ignored.

Besides producing the expanded word, the block sorts the special encodings into separate status outputs. These are the illegal all-zero halfword and unmatched patterns, reserved forms with a zero register or a zero immediate, hints, the no-op, and the breakpoint. A downstream decoder can then raise the right exception or skip the instruction without decoding the halfword a second time. The expansion logic is purely combinational. A parameter chooses whether the results pass through one register stage or leave the block directly.

Top module: `rvc_expander`

## Requirements
- R1: When `instr[1:0]` is `2'b11`, `out_word` equals the full 32-bit `instr` and every status flag is low.
- R2: The all-zero halfword, and any halfword that matches no supported form (for example `0x2000` and `0x9C41`), raise `out_illegal` and drive `out_word` to 0.
- R3: Loads and stores relative to the stack pointer and to a register expand to `lw`/`ld`/`sw`/`sd`. The expansion uses zero-extended scaled offsets, x2 as the base for the stack forms, and 3-bit register fields taken from bits 4:2 or 9:7 with 8 added (x8 to x15). Example: `0x4488` gives `lw x10, 8(x9)` = `0x0084A503`.
- R4: The unconditional jump expands to `jal x0` with a sign-extended 12-bit offset. The zero branches expand to `beq`/`bne rs1', x0` (funct3 000 / 001) with a sign-extended 9-bit offset. Examples: `0xBFFD` gives `0xFFFFF06F`, and `0xDC7D` gives `0xFE040FE3`.
- R5: The immediate forms expand as follows. Load-immediate gives `addi rd, x0, imm6`. Load-upper gives `lui rd, sext(imm6)`. Add-immediate gives `addi rd, rd, imm6`. The word form gives `addiw`. The stack adjust (load-upper slot with rd = x2) gives `addi x2, x2, imm10*16`. The scaled stack-pointer add gives `addi rd', x2, uimm`. Examples: `0x7101` gives `0xE0010113`, `0x7081` gives `0xFFFE00B7`, and `0x0024` gives `0x00810493`.
- R6: The immediate shifts, the and-immediate form and the two-register ALU group (sub, xor, or, and, subw, addw) expand to their standard OP-IMM, OP and OP-32 encodings, with the arithmetic right shift setting bit 30.
- R7: The move form gives `add rd, x0, rs2`. The add form gives `add rd, rd, rs2`. The indirect jump gives `jalr x0, rs1, 0`. The indirect call gives `jalr x1, rs1, 0`.
- R8: These forms raise `out_reserved` and drive `out_word` to 0: the scaled stack-pointer add with a zero immediate, the stack word or doubleword load with rd = x0, the indirect jump with rs1 = x0, the stack adjust with a zero immediate, and the word add-immediate with rd = x0.
- R9: These forms raise `out_hint` and still output their plain expansion: the left shift with rd = x0 or a zero shift amount, the right shifts with a zero shift amount, the move with rd = x0, and load-upper with rd = x0.
- R10: Add-immediate with rd = x0 raises `out_nop` and outputs `addi x0, x0, imm6` (`0x0001` gives `0x00000013`).
- R11: The halfword `0x9002` raises `out_brk` and outputs the breakpoint encoding `0x00100073`.
- R12: At most one status flag is high at a time. While `out_valid` is low, `out_word` and all flags are 0.
- R13: With `REG_OUT` = 1, `out_valid` and all results appear one clock after the inputs are sampled. With `REG_OUT` = 0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `instr` |
| instr | input | 32 | Instruction word; low half is compressed unless bits 1:0 are 11 |
| out_valid | output | 1 | Result qualifier |
| out_word | output | 32 | Expanded 32-bit instruction |
| out_illegal | output | 1 | Illegal or unmatched halfword |
| out_reserved | output | 1 | Reserved form |
| out_hint | output | 1 | Hint form, expansion still valid |
| out_nop | output | 1 | No-op form |
| out_brk | output | 1 | Breakpoint |

## Verification
Classification and expansion take place in the same cycle, so a hint or no-op halfword must yield both its flag and a correct expanded word, while a reserved or illegal one must yield its flag and a zero word. The bench judges each result by comparing the word and all five flags together against hand-built encodings. Because successive instructions share the output register, the bench also feeds different classes back to back, such as reserved followed by a pass-through and breakpoint followed by an idle cycle. This confirms that no flag or word from one cycle leaks into the next.

// File: rtl/rvc_xp_pkg.sv
package rvc_xp_pkg;

   localparam logic [6:0] OP_LD    = 7'b0000011;
   localparam logic [6:0] OP_ST    = 7'b0100011;
   localparam logic [6:0] OP_IMM   = 7'b0010011;
   localparam logic [6:0] OP_IMM32 = 7'b0011011;
   localparam logic [6:0] OP_R     = 7'b0110011;
   localparam logic [6:0] OP_R32   = 7'b0111011;
   localparam logic [6:0] OP_LUI   = 7'b0110111;
   localparam logic [6:0] OP_JAL   = 7'b1101111;
   localparam logic [6:0] OP_JALR  = 7'b1100111;
   localparam logic [6:0] OP_BR    = 7'b1100011;

   localparam logic [4:0] X_ZERO = 5'd0;
   localparam logic [4:0] X_RA   = 5'd1;
   localparam logic [4:0] X_SP   = 5'd2;

   localparam logic [2:0] F_W = 3'b010;
   localparam logic [2:0] F_D = 3'b011;

   localparam logic [31:0] EBREAK_WORD = 32'h0010_0073;

   typedef struct packed {
      logic [31:0] word;
      logic        illegal;
      logic        reserved;
      logic        hint;
      logic        nop;
      logic        brk;
   } xp_res_t;

   function automatic logic [31:0] f_i(logic [11:0] imm, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
      return {imm, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] f_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
      return {f7, rs2, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] f_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [6:0] op);
      return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
   endfunction

   function automatic logic [31:0] f_b(logic [12:1] off, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3);
      return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], OP_BR};
   endfunction

   function automatic logic [31:0] f_j(logic [20:1] off, logic [4:0] rd);
      return {off[20], off[10:1], off[11], off[19:12], rd, OP_JAL};
   endfunction

   function automatic logic [31:0] f_u(logic [19:0] imm, logic [4:0] rd, logic [6:0] op);
      return {imm, rd, op};
   endfunction

endpackage

// File: rtl/rvc_xp_q0.sv
module rvc_xp_q0
   import rvc_xp_pkg::*;
(
   input  logic [15:2] c,
   output xp_res_t     r
);
   logic [4:0] rdp, rs1p;
   logic [9:0] nzu;
   logic [6:0] woff;
   logic [7:0] doff;

   assign rdp  = {2'b01, c[4:2]};
   assign rs1p = {2'b01, c[9:7]};
   assign nzu  = {c[10:7], c[12:11], c[5], c[6], 2'b00};
   assign woff = {c[5], c[12:10], c[6], 2'b00};
   assign doff = {c[6:5], c[12:10], 3'b000};

   always_comb begin
      r = '0;
      unique case (c[15:13])
         3'b000: begin
            if (c[15:2] == '0)  r.illegal  = 1'b1;
            else if (nzu == '0) r.reserved = 1'b1;
            else r.word = f_i({2'b00, nzu}, X_SP, 3'b000, rdp, OP_IMM);
         end
         3'b010: r.word = f_i({5'b0, woff}, rs1p, F_W, rdp, OP_LD);
         3'b011: r.word = f_i({4'b0, doff}, rs1p, F_D, rdp, OP_LD);
         3'b110: r.word = f_s({5'b0, woff}, rdp, rs1p, F_W, OP_ST);
         3'b111: r.word = f_s({4'b0, doff}, rdp, rs1p, F_D, OP_ST);
         default: r.illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/rvc_xp_q1.sv
module rvc_xp_q1
   import rvc_xp_pkg::*;
(
   input  logic [15:2] c,
   output xp_res_t     r
);
   logic [4:0]  rd, rdp, rs2p;
   logic [5:0]  imm6;
   logic [11:0] sx12, sp12;
   logic [9:4]  sp16;
   logic [11:1] joff;
   logic [8:1]  boff;
   logic [19:0] up20;

   assign rd   = c[11:7];
   assign rdp  = {2'b01, c[9:7]};
   assign rs2p = {2'b01, c[4:2]};
   assign imm6 = {c[12], c[6:2]};
   assign sx12 = {{6{imm6[5]}}, imm6};
   assign sp16 = {c[12], c[4:3], c[5], c[2], c[6]};
   assign sp12 = {{2{sp16[9]}}, sp16, 4'b0000};
   assign joff = {c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3]};
   assign boff = {c[12], c[6:5], c[2], c[11:10], c[4:3]};
   assign up20 = {{14{imm6[5]}}, imm6};

   always_comb begin
      r = '0;
      unique case (c[15:13])
         3'b000: begin
            r.nop  = (rd == X_ZERO);
            r.word = f_i(sx12, rd, 3'b000, rd, OP_IMM);
         end
         3'b001: begin
            if (rd == X_ZERO) r.reserved = 1'b1;
            else r.word = f_i(sx12, rd, 3'b000, rd, OP_IMM32);
         end
         3'b010: r.word = f_i(sx12, X_ZERO, 3'b000, rd, OP_IMM);
         3'b011: begin
            if (rd == X_SP) begin
               if (sp16 == '0) r.reserved = 1'b1;
               else r.word = f_i(sp12, X_SP, 3'b000, X_SP, OP_IMM);
            end else begin
               r.hint = (rd == X_ZERO);
               r.word = f_u(up20, rd, OP_LUI);
            end
         end
         3'b100: begin
            unique case (c[11:10])
               2'b00: begin
                  r.hint = (imm6 == '0);
                  r.word = f_i({6'b000000, imm6}, rdp, 3'b101, rdp, OP_IMM);
               end
               2'b01: begin
                  r.hint = (imm6 == '0);
                  r.word = f_i({6'b010000, imm6}, rdp, 3'b101, rdp, OP_IMM);
               end
               2'b10: r.word = f_i(sx12, rdp, 3'b111, rdp, OP_IMM);
               default: begin
                  unique case ({c[12], c[6:5]})
                     3'b000: r.word = f_r(7'b0100000, rs2p, rdp, 3'b000, rdp, OP_R);
                     3'b001: r.word = f_r(7'b0000000, rs2p, rdp, 3'b100, rdp, OP_R);
                     3'b010: r.word = f_r(7'b0000000, rs2p, rdp, 3'b110, rdp, OP_R);
                     3'b011: r.word = f_r(7'b0000000, rs2p, rdp, 3'b111, rdp, OP_R);
                     3'b100: r.word = f_r(7'b0100000, rs2p, rdp, 3'b000, rdp, OP_R32);
                     3'b101: r.word = f_r(7'b0000000, rs2p, rdp, 3'b000, rdp, OP_R32);
                     default: r.illegal = 1'b1;
                  endcase
               end
            endcase
         end
         3'b101: r.word = f_j({{9{joff[11]}}, joff}, X_ZERO);
         3'b110: r.word = f_b({{4{boff[8]}}, boff}, X_ZERO, rdp, 3'b000);
         default: r.word = f_b({{4{boff[8]}}, boff}, X_ZERO, rdp, 3'b001);
      endcase
   end
endmodule

// File: rtl/rvc_xp_q2.sv
module rvc_xp_q2
   import rvc_xp_pkg::*;
(
   input  logic [15:2] c,
   output xp_res_t     r
);
   logic [4:0] rd, rs2;
   logic [5:0] sh;
   logic [7:2] lw_off, sw_off;
   logic [8:3] ld_off, sd_off;

   assign rd     = c[11:7];
   assign rs2    = c[6:2];
   assign sh     = {c[12], c[6:2]};
   assign lw_off = {c[3:2], c[12], c[6:4]};
   assign ld_off = {c[4:2], c[12], c[6:5]};
   assign sw_off = {c[8:7], c[12:9]};
   assign sd_off = {c[9:7], c[12:10]};

   always_comb begin
      r = '0;
      unique case (c[15:13])
         3'b000: begin
            r.hint = (rd == X_ZERO) || (sh == '0);
            r.word = f_i({6'b000000, sh}, rd, 3'b001, rd, OP_IMM);
         end
         3'b010: begin
            if (rd == X_ZERO) r.reserved = 1'b1;
            else r.word = f_i({4'b0, lw_off, 2'b00}, X_SP, F_W, rd, OP_LD);
         end
         3'b011: begin
            if (rd == X_ZERO) r.reserved = 1'b1;
            else r.word = f_i({3'b0, ld_off, 3'b000}, X_SP, F_D, rd, OP_LD);
         end
         3'b100: begin
            if (!c[12]) begin
               if (rs2 == X_ZERO) begin
                  if (rd == X_ZERO) r.reserved = 1'b1;
                  else r.word = f_i(12'd0, rd, 3'b000, X_ZERO, OP_JALR);
               end else begin
                  r.hint = (rd == X_ZERO);
                  r.word = f_r(7'd0, rs2, X_ZERO, 3'b000, rd, OP_R);
               end
            end else begin
               if (rs2 == X_ZERO) begin
                  if (rd == X_ZERO) begin
                     r.brk  = 1'b1;
                     r.word = EBREAK_WORD;
                  end else r.word = f_i(12'd0, rd, 3'b000, X_RA, OP_JALR);
               end else r.word = f_r(7'd0, rs2, rd, 3'b000, rd, OP_R);
            end
         end
         3'b110: r.word = f_s({4'b0, sw_off, 2'b00}, rs2, X_SP, F_W, OP_ST);
         3'b111: r.word = f_s({3'b0, sd_off, 3'b000}, rs2, X_SP, F_D, OP_ST);
         default: r.illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/rvc_xp_stage.sv
module rvc_xp_stage
   import rvc_xp_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    d_vld,
   input  xp_res_t d,
   output logic    q_vld,
   output xp_res_t q
);
   generate
      if (REG_OUT != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_vld <= 1'b0;
               q     <= '0;
            end else begin
               q_vld <= d_vld;
               q     <= d;
            end
         end
      end else begin : g_wire
         assign q_vld = d_vld;
         assign q     = d;
      end
   endgenerate
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
   import rvc_xp_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [31:0] instr,
   output logic        out_valid,
   output logic [31:0] out_word,
   output logic        out_illegal,
   output logic        out_reserved,
   output logic        out_hint,
   output logic        out_nop,
   output logic        out_brk
);
   localparam int CLEN = 16;
   localparam logic [1:0] FULL_LEN = 2'b11;

   generate
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg_out
         $error("rvc_expander: REG_OUT must be 0 or 1");
      end
   endgenerate

   xp_res_t r_q0, r_q1, r_q2, r_sel, r_out;

   rvc_xp_q0 u_q0 (.c(instr[CLEN-1:2]), .r(r_q0));
   rvc_xp_q1 u_q1 (.c(instr[CLEN-1:2]), .r(r_q1));
   rvc_xp_q2 u_q2 (.c(instr[CLEN-1:2]), .r(r_q2));

   always_comb begin
      r_sel = '0;
      if (in_valid) begin
         unique case (instr[1:0])
            2'b00:    r_sel = r_q0;
            2'b01:    r_sel = r_q1;
            2'b10:    r_sel = r_q2;
            FULL_LEN: r_sel.word = instr;
         endcase
      end
   end

   rvc_xp_stage #(.REG_OUT(REG_OUT)) u_stage (
      .clk(clk), .rst_n(rst_n), .d_vld(in_valid), .d(r_sel),
      .q_vld(out_valid), .q(r_out));

   assign out_word     = r_out.word;
   assign out_illegal  = r_out.illegal;
   assign out_reserved = r_out.reserved;
   assign out_hint     = r_out.hint;
   assign out_nop      = r_out.nop;
   assign out_brk      = r_out.brk;
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk #(
   parameter int REG_OUT = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] instr,
   input logic        out_valid,
   input logic [31:0] out_word,
   input logic        out_illegal,
   input logic        out_reserved,
   input logic        out_hint,
   input logic        out_nop,
   input logic        out_brk
);
   logic        ref_vld;
   logic [31:0] ref_in;
   logic [4:0]  flags;

   assign flags = {out_illegal, out_reserved, out_hint, out_nop, out_brk};

   generate
      if (REG_OUT != 0) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_vld <= 1'b0;
               ref_in  <= '0;
            end else begin
               ref_vld <= in_valid;
               ref_in  <= instr;
            end
         end
      end else begin : g_now
         assign ref_vld = in_valid;
         assign ref_in  = instr;
      end
   endgenerate

   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flags)); // R12
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (flags == 5'b0 && out_word == 32'h0)); // R12
   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == ref_vld); // R13
   AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_vld && ref_in[1:0] == 2'b11) |-> (out_word == ref_in && flags == 5'b0)); // R1
   AST_ZERO_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_vld && ref_in[15:0] == 16'h0) |-> (out_illegal && out_word == 32'h0)); // R2
   AST_DEAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_illegal || out_reserved) |-> out_word == 32'h0); // R8
   AST_BRK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_vld && ref_in[15:0] == 16'h9002) |-> (out_brk && out_word == 32'h0010_0073)); // R11
   AST_NOP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      out_nop |-> (ref_in[15:13] == 3'b000 && ref_in[11:7] == 5'd0 && ref_in[1:0] == 2'b01)); // R10
endmodule

bind rvc_expander rvc_expander_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
   .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal),
   .out_reserved(out_reserved), .out_hint(out_hint), .out_nop(out_nop),
   .out_brk(out_brk));

// File: tb/sim_rvc_expander.sv
module sim_rvc_expander;
   localparam time CLK_HALF = 10ns;   // 50 MHz
   localparam int  WD_CYCLES = 100000;

   // flag vector order: {illegal, reserved, hint, nop, brk}
   localparam logic [4:0] FL_NONE = 5'b00000;
   localparam logic [4:0] FL_ILL  = 5'b10000;
   localparam logic [4:0] FL_RES  = 5'b01000;
   localparam logic [4:0] FL_HINT = 5'b00100;
   localparam logic [4:0] FL_NOP  = 5'b00010;
   localparam logic [4:0] FL_BRK  = 5'b00001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        out_illegal, out_reserved, out_hint, out_nop, out_brk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   rvc_expander u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal),
      .out_reserved(out_reserved), .out_hint(out_hint), .out_nop(out_nop),
      .out_brk(out_brk));

   task automatic judge(input string tag, input logic ev, input logic [31:0] ew,
                        input logic [4:0] ef);
      logic [4:0] af;
      af = {out_illegal, out_reserved, out_hint, out_nop, out_brk};
      n_chk++;
      if (out_valid !== ev || out_word !== ew || af !== ef) begin
         n_fail++;
         $display("FAIL %s: got vld=%b word=%h flags=%b, expected vld=%b word=%h flags=%b",
                  tag, out_valid, out_word, af, ev, ew, ef);
      end
   endtask

   // drive one word, result is visible after the next rising edge (one register)
   task automatic apply(input string tag, input logic [31:0] v,
                        input logic [31:0] ew, input logic [4:0] ef);
      @(negedge clk);
      in_valid = 1'b1;
      instr    = v;
      @(posedge clk);
      #1;
      judge(tag, 1'b1, ew, ef);
   endtask

   task automatic t_reset;
      #1;
      judge("R12 reset", 1'b0, 32'h0, FL_NONE);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_passthru;
      apply("R1 full-length addi",    32'h00A0_0513, 32'h00A0_0513, FL_NONE);
      apply("R1 full-length all-one", 32'hFFFF_FFFF, 32'hFFFF_FFFF, FL_NONE);
   endtask

   task automatic t_loadstore;
      apply("R3 lw",   32'h0000_4488, 32'h0084_A503, FL_NONE);
      apply("R3 ld",   32'h0000_6488, 32'h0084_B503, FL_NONE);
      apply("R3 sw",   32'h0000_C488, 32'h00A4_A423, FL_NONE);
      apply("R3 sd",   32'h0000_E488, 32'h00A4_B423, FL_NONE);
      apply("R3 lwsp", 32'h0000_4082, 32'h0001_2083, FL_NONE);
      apply("R3 ldsp", 32'h0000_6082, 32'h0001_3083, FL_NONE);
      apply("R3 ldsp max offset", 32'h0000_72FE, 32'h1F81_3283, FL_NONE);
      apply("R3 swsp", 32'h0000_C006, 32'h0011_2023, FL_NONE);
      apply("R3 sdsp", 32'h0000_E006, 32'h0011_3023, FL_NONE);
   endtask

   task automatic t_ctrl;
      apply("R4 j zero",   32'h0000_A001, 32'h0000_006F, FL_NONE);
      apply("R4 j minus2", 32'h0000_BFFD, 32'hFFFF_F06F, FL_NONE);
      apply("R4 beqz",     32'h0000_C081, 32'h0004_8063, FL_NONE);
      apply("R4 bnez",     32'h0000_E081, 32'h0004_9063, FL_NONE);
      apply("R4 beqz minus2", 32'h0000_DC7D, 32'hFE04_0FE3, FL_NONE);
   endtask

   task automatic t_imm;
      apply("R5 addi4spn", 32'h0000_0024, 32'h0081_0493, FL_NONE);
      apply("R5 addi -31", 32'h0000_1085, 32'hFE10_8093, FL_NONE);
      apply("R5 addiw",    32'h0000_2081, 32'h0000_809B, FL_NONE);
      apply("R5 li",       32'h0000_4081, 32'h0000_0093, FL_NONE);
      apply("R5 addi16sp", 32'h0000_7101, 32'hE001_0113, FL_NONE);
      apply("R5 lui",      32'h0000_7081, 32'hFFFE_00B7, FL_NONE);
   endtask

   task automatic t_alu;
      apply("R6 srli", 32'h0000_8085, 32'h0014_D493, FL_NONE);
      apply("R6 srai", 32'h0000_8485, 32'h4014_D493, FL_NONE);
      apply("R6 andi", 32'h0000_8881, 32'h0004_F493, FL_NONE);
      apply("R6 slli", 32'h0000_1082, 32'h0200_9093, FL_NONE);
      apply("R6 sub",  32'h0000_8C85, 32'h4094_84B3, FL_NONE);
      apply("R6 xor",  32'h0000_8CA5, 32'h0094_C4B3, FL_NONE);
      apply("R6 or",   32'h0000_8CC5, 32'h0094_E4B3, FL_NONE);
      apply("R6 and",  32'h0000_8CE5, 32'h0094_F4B3, FL_NONE);
      apply("R6 subw", 32'h0000_9C85, 32'h4094_84BB, FL_NONE);
      apply("R6 addw", 32'h0000_9CA5, 32'h0094_84BB, FL_NONE);
   endtask

   task automatic t_regops;
      apply("R7 mv",   32'h0000_8086, 32'h0010_00B3, FL_NONE);
      apply("R7 add",  32'h0000_9086, 32'h0010_80B3, FL_NONE);
      apply("R7 jr",   32'h0000_8082, 32'h0000_8067, FL_NONE);
      apply("R7 jalr", 32'h0000_9082, 32'h0000_80E7, FL_NONE);
   endtask

   task automatic t_illegal;
      apply("R2 zero halfword",       32'h0000_0000, 32'h0, FL_ILL);
      apply("R2 zero low, junk high", 32'hABCD_0000, 32'h0, FL_ILL);
      apply("R2 unmatched q0",        32'h0000_2000, 32'h0, FL_ILL);
      apply("R2 unmatched alu",       32'h0000_9C41, 32'h0, FL_ILL);
   endtask

   task automatic t_reserved;
      apply("R8 addi4spn zero imm", 32'h0000_0010, 32'h0, FL_RES);
      apply("R8 lwsp x0",           32'h0000_4002, 32'h0, FL_RES);
      apply("R8 ldsp x0",           32'h0000_6002, 32'h0, FL_RES);
      apply("R8 jr x0",             32'h0000_8002, 32'h0, FL_RES);
      apply("R8 addi16sp zero",     32'h0000_6101, 32'h0, FL_RES);
      apply("R8 addiw x0",          32'h0000_2001, 32'h0, FL_RES);
   endtask

   task automatic t_hint;
      apply("R9 slli rd x0",   32'h0000_1002, 32'h0200_1013, FL_HINT);
      apply("R9 slli zero sh", 32'h0000_0082, 32'h0000_9093, FL_HINT);
      apply("R9 srli zero sh", 32'h0000_8001, 32'h0004_5413, FL_HINT);
      apply("R9 mv rd x0",     32'h0000_8006, 32'h0010_0033, FL_HINT);
      apply("R9 lui rd x0",    32'h0000_7001, 32'hFFFE_0037, FL_HINT);
   endtask

   task automatic t_nop_brk;
      apply("R10 nop imm -32", 32'h0000_1001, 32'hFE00_0013, FL_NOP);
      apply("R10 nop imm 0",   32'h0000_0001, 32'h0000_0013, FL_NOP);
      apply("R11 breakpoint",  32'h0000_9002, 32'h0010_0073, FL_BRK);
   endtask

   // mixed classes back to back, then an idle cycle with a flagged pattern on instr
   task automatic t_mixed;
      apply("R8 reserved then", 32'h0000_4002, 32'h0,          FL_RES);
      apply("R1 passthru after reserved", 32'h0010_0073, 32'h0010_0073, FL_NONE);
      apply("R11 brk then",     32'h0000_9002, 32'h0010_0073, FL_BRK);
      @(negedge clk);
      in_valid = 1'b0;
      instr    = 32'h0000_0000;
      @(posedge clk);
      #1;
      judge("R12 idle after brk", 1'b0, 32'h0, FL_NONE);
      apply("R13 one-cycle latency", 32'h0000_4081, 32'h0000_0093, FL_NONE);
   endtask

   initial begin
      t_reset();
      t_passthru();
      t_loadstore();
      t_ctrl();
      t_imm();
      t_alu();
      t_regops();
      t_illegal();
      t_reserved();
      t_hint();
      t_nop_brk();
      t_mixed();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got running, expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule